// File: doc/BRIEF.md
# Indexed Block Register Slave on SMBus

This block is a small configuration register file that sits on an SMBus two-wire bus. It answers to one 8-bit bus address, D2h for writes and D3h for reads. It holds 21 byte-wide registers and presents all of them at once on a flat parallel output bus for the logic around it. SCL and SDA are plain inputs that the system clock samples. The block pulls SDA low through a single output-enable pin, so the bus stays open-drain.

A write transaction gives a starting index, then a byte count, then that many data bytes. The data bytes land in consecutive registers. A read transaction first sets the index with a short write phase and then issues a repeated start with the read address. The slave then sends a count byte, which it takes from a writable count register, and after it the data bytes from the index onwards. The master acknowledges each byte it wants to continue with and ends the read with a not-acknowledge and a stop.

One register is fixed. It holds a revision code in its upper four bits and a vendor code in its lower four bits. Bit 7 of register 14 is reserved and always reads zero.

Top module: `smb_idx_slave`

## Requirements
- R1: After reset the slave does not drive SDA. Register 8 (the count register) reads 0Fh, register 7 reads 21h (revision code 2 in bits 7:4, vendor code 1 in bits 3:0), and all other registers read 00h.
- R2: For a write, the slave acknowledges the address byte D2h, the index byte N and the count byte X. It then stores data byte k (k from 0) in register N+k, and the result appears on `cfg_o` bits [8*(N+k)+7 : 8*(N+k)].
- R3: For a read, the master sends D2h and the index N, then a repeated start and D3h. The slave acknowledges D3h, sends the current value of register 8 as the first byte, and then sends registers N, N+1 and so on, most significant bit first. It keeps sending while the master acknowledges and releases SDA after a not-acknowledge.
- R4: Register 8 can be written. The count byte of every later read equals the value written, including values with bit 7 set.
- R5: Writes to register 7 leave it unchanged. Bit 7 of register 14 ignores writes and stays 0, while its bits 6:0 take the written data.
- R6: An address byte other than D2h or D3h is not acknowledged. The slave ignores the bus until the next start condition, so no register changes, and it then handles a valid transaction normally.
- R7: A data byte aimed at an index of 21 or above is still acknowledged within the count but changes no register. A read byte from such an index is 00h.
- R8: Data bytes beyond the byte count are not acknowledged and are not stored.
- R9: A stop or a start condition that arrives before a byte's 8 bits are complete drops that byte. Registers completed earlier in the same transaction keep their new values. After a start condition, the slave takes the new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | SMBus clock line as seen on the wire |
| sda_i | input | 1 | SMBus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge or a 0 data bit) |
| cfg_o | output | 168 | All registers; register i is on bits [8i+7:8i] |

## Verification
Two actions share one sampled SCL falling edge. The slave releases its acknowledge of the read address and, in the same cycle, starts driving the most significant bit of the count byte. The bench covers this by reading with count register values of 0Fh and 83h, so the first driven bit is 0 in one case and 1 in the other. It judges the result by comparing every received count byte against its model through the scoreboard. The bench also places a stop and a start condition partway through a data byte, right after a completed byte. It checks on `cfg_o` that the completed byte is kept and that the partial byte leaves no trace.

// File: rtl/smb_idx_pkg.sv
package smb_idx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } st_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_INDEX,
        RL_COUNT,
        RL_DATA
    } role_e;

    typedef struct packed {
        st_e        st;
        role_e      role;
        logic [3:0] bcnt;
        logic [7:0] sh;
        logic [7:0] idx;
        logic [7:0] rem;
        logic       oe;
        logic       go_tx;
        logic       mack;
    } fsm_t;

    // Writable bits per register: the identity register is fully fixed,
    // the reserved top bit of the spread register stays zero.
    function automatic logic [7:0] wr_mask(int i, int id_reg, int rsv_reg);
        if (i == id_reg)
            return 8'h00;
        else if (i == rsv_reg)
            return 8'h7F;
        else
            return 8'hFF;
    endfunction

    // Index advance that parks at the top instead of wrapping back into range.
    function automatic logic [7:0] sat_inc(logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

endpackage

// File: rtl/smb_edge_det.sv
module smb_edge_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    typedef struct packed {
        logic [SYNC-1:0] scl_sh;
        logic [SYNC-1:0] sda_sh;
        logic            scl_p;
        logic            sda_p;
    } sync_t;

    sync_t d, q;
    logic  scl_s;

    always_comb begin
        d        = q;
        d.scl_sh = {q.scl_sh[SYNC-2:0], scl_i};
        d.sda_sh = {q.sda_sh[SYNC-2:0], sda_i};
        scl_s    = q.scl_sh[SYNC-1];
        sda_s    = q.sda_sh[SYNC-1];
        d.scl_p  = scl_s;
        d.sda_p  = sda_s;
        scl_rise = scl_s & ~q.scl_p;
        scl_fall = ~scl_s & q.scl_p;
        start_c  = scl_s & q.scl_p & q.sda_p & ~sda_s;
        stop_c   = scl_s & q.scl_p & ~q.sda_p & sda_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.scl_sh <= '1;
            q.sda_sh <= '1;
            q.scl_p  <= 1'b1;
            q.sda_p  <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_idx_pkg::*;
#(
    parameter int         NUM_REGS = 21,
    parameter int         ID_REG   = 7,
    parameter int         CNT_REG  = 8,
    parameter int         RSV_REG  = 14,
    parameter logic [7:0] ID_VAL   = 8'h21,
    parameter logic [7:0] CNT_RST  = 8'h0F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    input  logic [7:0]            rd_idx,
    output logic [7:0]            rd_data,
    output logic [7:0]            cnt_val,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    logic [7:0] regs_d [NUM_REGS];
    logic [7:0] regs_q [NUM_REGS];

    function automatic logic [7:0] rst_val(int i);
        if (i == ID_REG)
            return ID_VAL;
        else if (i == CNT_REG)
            return CNT_RST;
        else
            return 8'h00;
    endfunction

    always_comb begin
        regs_d  = regs_q;
        rd_data = 8'h00;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (wr_en && wr_idx == 8'(i))
                regs_d[i] = (regs_q[i] & ~wr_mask(i, ID_REG, RSV_REG))
                          | (wr_data & wr_mask(i, ID_REG, RSV_REG));
            if (rd_idx == 8'(i))
                rd_data = regs_q[i];
        end
        cnt_val = regs_q[CNT_REG];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++)
                regs_q[i] <= rst_val(i);
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign cfg_o[g*8 +: 8] = regs_q[g];
    end
endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smb_idx_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'hD2,
    parameter int         NUM_REGS = 21
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_c,
    input  logic       stop_c,
    input  logic       sda_s,
    input  logic [7:0] rd_data,
    input  logic [7:0] cnt_val,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic [7:0] rd_idx,
    output logic       sda_oe
);
    localparam logic [7:0] ADDR_RD = DEV_ADDR | 8'h01;
    localparam logic [7:0] LAST    = 8'(NUM_REGS - 1);

    fsm_t d, q;

    always_comb begin
        d       = q;
        wr_en   = 1'b0;
        wr_idx  = q.idx;
        wr_data = q.sh;
        if (start_c) begin
            d.st    = ST_RX;
            d.role  = RL_ADDR;
            d.bcnt  = 4'd0;
            d.oe    = 1'b0;
            d.go_tx = 1'b0;
        end else if (stop_c) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.bcnt != 4'd8) begin
                        d.sh   = {q.sh[6:0], sda_s};
                        d.bcnt = q.bcnt + 4'd1;
                    end else if (scl_fall && q.bcnt == 4'd8) begin
                        d.bcnt  = 4'd0;
                        d.st    = ST_ACK;
                        d.oe    = 1'b1;
                        d.go_tx = 1'b0;
                        case (q.role)
                            RL_ADDR: begin
                                if (q.sh == DEV_ADDR) begin
                                    d.role = RL_INDEX;
                                end else if (q.sh == ADDR_RD) begin
                                    d.go_tx = 1'b1;
                                end else begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                            RL_INDEX: begin
                                d.idx  = q.sh;
                                d.role = RL_COUNT;
                            end
                            RL_COUNT: begin
                                d.rem  = q.sh;
                                d.role = RL_DATA;
                            end
                            default: begin
                                if (q.rem != 8'd0) begin
                                    wr_en = (q.idx <= LAST);
                                    d.idx = sat_inc(q.idx);
                                    d.rem = q.rem - 8'd1;
                                end else begin
                                    d.st = ST_IDLE;
                                    d.oe = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (q.go_tx) begin
                            d.st   = ST_TX;
                            d.sh   = cnt_val;
                            d.oe   = ~cnt_val[7];
                            d.bcnt = 4'd1;
                        end else begin
                            d.st   = ST_RX;
                            d.oe   = 1'b0;
                            d.bcnt = 4'd0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bcnt == 4'd8) begin
                            d.st = ST_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.sh   = {q.sh[6:0], 1'b0};
                            d.oe   = ~q.sh[6];
                            d.bcnt = q.bcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st   = ST_TX;
                            d.sh   = rd_data;
                            d.oe   = ~rd_data[7];
                            d.bcnt = 4'd1;
                            d.idx  = sat_inc(q.idx);
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
        rd_idx = q.idx;
        sda_oe = q.oe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.role  <= RL_ADDR;
            q.bcnt  <= 4'd0;
            q.sh    <= 8'h00;
            q.idx   <= 8'h00;
            q.rem   <= 8'h00;
            q.oe    <= 1'b0;
            q.go_tx <= 1'b0;
            q.mack  <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/smb_idx_slave.sv
module smb_idx_slave #(
    parameter int         NUM_REGS = 21,
    parameter logic [7:0] DEV_ADDR = 8'hD2,
    parameter int         ID_REG   = 7,
    parameter int         CNT_REG  = 8,
    parameter int         RSV_REG  = 14,
    parameter logic [3:0] REV_ID   = 4'h2,
    parameter logic [3:0] VEN_ID   = 4'h1,
    parameter logic [7:0] CNT_RST  = 8'h0F,
    parameter int         SYNC     = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] cfg_o
);
    localparam logic [7:0] ID_VAL = {REV_ID, VEN_ID};

    logic       sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data, rd_idx, rd_data, cnt_val;

    smb_edge_det #(.SYNC(SYNC)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    smb_proto_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c),
        .sda_s    (sda_s),
        .rd_data  (rd_data),
        .cnt_val  (cnt_val),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .sda_oe   (sda_oe_o)
    );

    smb_reg_bank #(
        .NUM_REGS (NUM_REGS),
        .ID_REG   (ID_REG),
        .CNT_REG  (CNT_REG),
        .RSV_REG  (RSV_REG),
        .ID_VAL   (ID_VAL),
        .CNT_RST  (CNT_RST)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cnt_val (cnt_val),
        .cfg_o   (cfg_o)
    );
endmodule

// File: rtl/smb_idx_slave_chk.sv
module smb_idx_slave_chk #(
    parameter int         NUM_REGS = 21,
    parameter int         ID_REG   = 7,
    parameter int         RSV_REG  = 14,
    parameter logic [7:0] ID_VAL   = 8'h21
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_i,
    input logic                  sda_oe_o,
    input logic [NUM_REGS*8-1:0] cfg_o,
    input logic                  wr_en,
    input logic [7:0]            wr_idx
);
    localparam logic [7:0] LAST = 8'(NUM_REGS - 1);

    // R2: the slave starts pulling SDA only while SCL is low
    a_r2_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R5: identity register never moves
    a_r5_id_const: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[ID_REG*8 +: 8] == ID_VAL);

    // R5: reserved bit stays clear
    a_r5_rsv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_o[RSV_REG*8 + 7]);

    // R9: register contents change only at a completed byte (SCL low)
    a_r9_cfg_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_o) |-> !scl_i);

    // R7: no write strobe reaches the bank for an index outside the file
    a_r7_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx <= LAST));
endmodule

bind smb_idx_slave smb_idx_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .ID_REG   (ID_REG),
    .RSV_REG  (RSV_REG),
    .ID_VAL   ({REV_ID, VEN_ID})
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe_o (sda_oe_o),
    .cfg_o    (cfg_o),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx)
);

// File: tb/sim_smb_idx_slave.sv
`timescale 1ns/1ps
module sim_smb_idx_slave;
    localparam int NREG = 21;
    localparam int Q    = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] cfg;
    wire  bus_sda = m_sda & ~sda_oe;

    smb_idx_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (bus_sda),
        .sda_oe_o (sda_oe),
        .cfg_o    (cfg)
    );

    int total = 0;
    int bad   = 0;
    logic done = 1'b0;
    logic [7:0] mdl  [NREG];
    logic [7:0] wbuf [16];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    string      tag_q [$];

    task automatic chk8(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] bmask(int i);
        if (i == 7) return 8'h00;
        if (i == 14) return 8'h7F;
        return 8'hFF;
    endfunction

    task automatic chk_cfg(string tag);
        for (int i = 0; i < NREG; i++)
            chk8($sformatf("%s reg%0d", tag, i), cfg[i*8 +: 8], mdl[i]);
    endtask

    task automatic tq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; tq(Q);
        m_sda = 1'b0; tq(Q);
        m_scl = 1'b0; tq(Q);
    endtask

    task automatic m_rstart();
        m_sda = 1'b1; tq(Q);
        m_scl = 1'b1; tq(Q);
        m_sda = 1'b0; tq(Q);
        m_scl = 1'b0; tq(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tq(Q);
        m_scl = 1'b1; tq(Q);
        m_sda = 1'b1; tq(Q);
    endtask

    task automatic m_wbit(logic b);
        m_sda = b; tq(Q);
        m_scl = 1'b1; tq(2*Q);
        m_scl = 1'b0; tq(Q);
    endtask

    task automatic m_rbit(output logic b);
        m_sda = 1'b1; tq(Q);
        m_scl = 1'b1; tq(Q);
        b = bus_sda; tq(Q);
        m_scl = 1'b0; tq(Q);
    endtask

    task automatic m_wbyte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_rbyte(logic last, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_rbit(v[i]);
        m_wbit(last);
    endtask

    task automatic blk_write(logic [7:0] idx, logic [7:0] cnt, int nsend, string tag);
        logic a;
        m_start();
        m_wbyte(8'hD2, a); chk8({tag, " addr ack"}, {7'd0, a}, 8'd1);
        m_wbyte(idx, a);   chk8({tag, " index ack"}, {7'd0, a}, 8'd1);
        m_wbyte(cnt, a);   chk8({tag, " count ack"}, {7'd0, a}, 8'd1);
        for (int i = 0; i < nsend; i++) begin
            m_wbyte(wbuf[i], a);
            chk8($sformatf("%s data%0d ack", tag, i), {7'd0, a}, {7'd0, (i < int'(cnt))});
            if (i < int'(cnt) && int'(idx) + i < NREG)
                mdl[int'(idx) + i] = (mdl[int'(idx) + i] & ~bmask(int'(idx) + i))
                                   | (wbuf[i] & bmask(int'(idx) + i));
        end
        m_stop();
    endtask

    task automatic blk_read(logic [7:0] idx, int n, string tag);
        logic a;
        logic [7:0] v;
        m_start();
        m_wbyte(8'hD2, a); chk8({tag, " addr ack"}, {7'd0, a}, 8'd1);
        m_wbyte(idx, a);   chk8({tag, " index ack"}, {7'd0, a}, 8'd1);
        m_rstart();
        m_wbyte(8'hD3, a); chk8({tag, " read addr ack"}, {7'd0, a}, 8'd1);
        exp_q.push_back(mdl[8]); tag_q.push_back({tag, " count byte"});
        m_rbyte(1'b0, v); got_q.push_back(v);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back((int'(idx) + i < NREG) ? mdl[int'(idx) + i] : 8'h00);
            tag_q.push_back($sformatf("%s data%0d", tag, i));
            m_rbyte(i == n - 1, v); got_q.push_back(v);
        end
        m_stop();
        chk8({tag, " released after nack"}, {7'd0, sda_oe}, 8'd0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            logic [7:0] g, e;
            string t;
            wait (got_q.size() != 0);
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk8(t, g, e);
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a;
        for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
        mdl[7] = 8'h21;
        mdl[8] = 8'h0F;
        tq(10);
        rst_n = 1'b1;
        tq(5);

        // R1 reset state
        chk8("R1 sda_oe idle", {7'd0, sda_oe}, 8'd0);
        chk_cfg("R1");

        // R2 block write
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
        blk_write(8'd2, 8'd4, 4, "R2");
        chk_cfg("R2");

        // R3 block read with default count byte 0F
        blk_read(8'd2, 4, "R3");
        blk_read(8'd0, 6, "R3 from zero");

        // R4 count register with msb set, then another value
        wbuf[0] = 8'h83;
        blk_write(8'd8, 8'd1, 1, "R4");
        blk_read(8'd1, 3, "R4 count 83");
        wbuf[0] = 8'h05;
        blk_write(8'd8, 8'd1, 1, "R4");
        blk_read(8'd3, 2, "R4 count 05");

        // R5 read-only register and reserved bit
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        blk_write(8'd6, 8'd3, 3, "R5");
        wbuf[0] = 8'hFF;
        blk_write(8'd14, 8'd1, 1, "R5 reserved");
        chk_cfg("R5");
        blk_read(8'd6, 3, "R5");

        // R6 wrong address
        m_start();
        m_wbyte(8'hA4, a); chk8("R6 wrong addr nack", {7'd0, a}, 8'd0);
        m_wbyte(8'h00, a); m_wbyte(8'h01, a); m_wbyte(8'h55, a);
        m_stop();
        chk_cfg("R6 unchanged");
        wbuf[0] = 8'h99;
        blk_write(8'd0, 8'd1, 1, "R6 recovery");
        chk_cfg("R6 recovery");

        // R7 out-of-range index
        wbuf[0] = 8'h61; wbuf[1] = 8'h62; wbuf[2] = 8'h63; wbuf[3] = 8'h64;
        blk_write(8'd19, 8'd4, 4, "R7");
        blk_write(8'd40, 8'd2, 2, "R7 far");
        chk_cfg("R7");
        blk_read(8'd19, 4, "R7");

        // R8 bytes past the count
        wbuf[0] = 8'h71; wbuf[1] = 8'h72; wbuf[2] = 8'h73; wbuf[3] = 8'h74;
        blk_write(8'd10, 8'd2, 4, "R8");
        chk_cfg("R8");

        // R9 stop in mid-byte
        m_start();
        m_wbyte(8'hD2, a); m_wbyte(8'd12, a); m_wbyte(8'd3, a);
        m_wbyte(8'h5A, a); chk8("R9 first byte ack", {7'd0, a}, 8'd1);
        mdl[12] = 8'h5A;
        m_wbit(1'b1); m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
        m_stop();
        chk_cfg("R9 stop abort");

        // R9 start in mid-byte, new transaction is taken
        m_start();
        m_wbyte(8'hD2, a); m_wbyte(8'd15, a); m_wbyte(8'd2, a);
        m_wbyte(8'h3C, a);
        mdl[15] = 8'h3C;
        m_wbit(1'b0); m_wbit(1'b1); m_wbit(1'b1);
        m_rstart();
        m_wbyte(8'hD2, a); chk8("R9 restart addr ack", {7'd0, a}, 8'd1);
        m_wbyte(8'd16, a); m_wbyte(8'd1, a); m_wbyte(8'h77, a);
        m_stop();
        mdl[16] = 8'h77;
        chk_cfg("R9 start abort");

        wait (got_q.size() == 0);
        tq(4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule